// File: doc/BRIEF.md
# Line Write Bus Master Sequencer

This block is the bus-master side of a 16-byte line write on a 32-bit data bus. It is used both for block-move operand stores and for cache line pushes. A request carries the line address, the transfer attributes and four data words. The block opens the transfer with a one-clock start strobe and holds transfer-in-progress for the whole access. It then puts the data words on the bus one beat at a time. Each beat finishes when the slave acknowledges it.

The slave answers the first acknowledge with a burst-inhibit level. If the slave accepts a burst, the remaining three words follow, one per acknowledged beat. If it refuses, the block stops after the first word and flags the refusal, so that a higher-level unit can reissue the rest as single transfers.

A configurable ignore delay keeps acknowledge from being sampled during the first clocks of every beat. A status output marks the first clock in which sampling is live.

Top module: `lwr_seq`

## Requirements
- R1: During and directly after a synchronous active-high reset, `bus_ts`, `bus_tip`, `bus_oe`, `bus_sas`, `done` and `burst_refused` are low, `bus_rw` is high, `bus_siz` is 2'b00 and `req_ready` is high.
- R2: A request accepted at a clock edge (`req_valid` high while `req_ready` is high) makes the next clock the address clock. In it, `bus_ts` and `bus_tip` are high, `bus_addr`/`bus_attr` carry the request, `bus_rw` is low and `bus_siz` is the line code 2'b11. `bus_ts` is high for that one clock only. `bus_rw` stays low and `bus_siz` stays 2'b11 for as long as `bus_tip` is high.
- R3: In the clock after the address clock, `bus_ts` is low, `bus_oe` is high and `bus_dout` carries word 0. Word i is `req_data[32*i+31:32*i]`, and the words are sent in ascending i.
- R4: With `cfg_ign_en` low, or with `cfg_ign_cnt` equal to 0, `bus_sas` is high in the first clock of each beat, and `bus_ta` is sampled at the end of that clock.
- R5: With `cfg_ign_en` high and `cfg_ign_cnt` = N (1..7), `bus_ta` is ignored during the first N clocks of every beat. `bus_sas` is high only in clock N+1 of the beat.
- R6: A sampling clock in which `bus_ta` is low is a wait state. The beat continues, `bus_dout` holds its word, `bus_sas` stays low, and `bus_ta`/`bus_tbi` are sampled again at the next edge.
- R7: When `bus_tbi` is low together with the first sampled acknowledge, words 1, 2 and 3 follow in order, each one advancing on the next sampled acknowledge.
- R8: `bus_tbi` is evaluated only together with the first acknowledge of the line. Its level at any other edge has no effect.
- R9: When `bus_tbi` is high with the first acknowledge, the transfer ends after word 0, and `burst_refused` is high in the same clock as `done`.
- R10: In the clock after the final acknowledge, `bus_tip` and `bus_oe` are low and `done` is high for exactly one clock. `req_ready` is high in the clock after that.
- R11: `req_valid` has no effect while `req_ready` is low. The address and attributes on the bus do not change, and no new start strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line write request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Line address |
| req_attr | input | 5 | Transfer attributes |
| req_data | input | 128 | Four data words, word 0 in the low bits |
| cfg_ign_en | input | 1 | Enable the acknowledge ignore delay |
| cfg_ign_cnt | input | 3 | Number of ignored clocks per beat |
| bus_addr | output | 32 | Address bus |
| bus_attr | output | 5 | Transfer attribute outputs |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_tip | output | 1 | Transfer in progress |
| bus_rw | output | 1 | Read/write, low for write |
| bus_siz | output | 2 | Transfer size, 2'b11 for a line |
| bus_dout | output | 32 | Write data |
| bus_oe | output | 1 | Data bus drive enable, low means released |
| bus_sas | output | 1 | First live sampling clock of a beat |
| bus_ta | input | 1 | Transfer acknowledge from slave |
| bus_tbi | input | 1 | Burst inhibit from slave |
| done | output | 1 | Line write finished |
| burst_refused | output | 1 | Slave refused the burst |

## Verification
Two events can land on the same edge: the first acknowledge of the line, which also decides the burst mode through `bus_tbi`, and the expiry of the ignore window. An acknowledge one clock earlier is still inside the window and must be dropped. The bench keeps `bus_ta` high through every ignored clock and often acknowledges in the very first sampling clock, with random `bus_tbi` levels, across ignore counts 0 to 7. It judges the outcome by checking, in every clock, which word is on `bus_dout`, whether `bus_sas` is high and whether `done`/`burst_refused` appear.

// File: rtl/lwr_pkg.sv
package lwr_pkg;

    localparam int LW_ADDR_W = 32;
    localparam int LW_ATTR_W = 5;
    localparam int LW_DATA_W = 32;
    localparam int LW_BEATS  = 4;
    localparam int LW_IGN_W  = 3;

    localparam logic [1:0] SIZ_NONE = 2'b00;
    localparam logic [1:0] SIZ_LINE = 2'b11;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_BEAT = 2'd2,
        S_END  = 2'd3
    } lw_state_e;

    typedef struct packed {
        logic                enable;
        logic [LW_IGN_W-1:0] count;
    } ign_cfg_t;

    // A zero count with the mode enabled is equivalent to disabled.
    function automatic logic [LW_IGN_W-1:0] ign_delay(input ign_cfg_t cfg);
        return cfg.enable ? cfg.count : '0;
    endfunction

endpackage

// File: rtl/lwr_ign_timer.sv
module lwr_ign_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             active,
    input  logic [CNT_W-1:0] delay,
    output logic             sample,
    output logic             first
);
    logic [CNT_W-1:0] remain_q;
    logic             live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            live_q   <= 1'b0;
        end else if (load) begin
            remain_q <= delay;
            live_q   <= 1'b0;
        end else if (active) begin
            if (remain_q != '0) begin
                remain_q <= remain_q - 1'b1;
            end else begin
                live_q <= 1'b1;
            end
        end
    end

    assign sample = active && (remain_q == '0);
    assign first  = sample && !live_q;
endmodule

// File: rtl/lwr_beat_path.sv
module lwr_beat_path #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int LINE_W = DATA_W * BEATS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LINE_W-1:0] line_in,
    input  logic              clear,
    input  logic              advance,
    output logic [BW-1:0]     beat_idx,
    output logic              last_beat,
    output logic [DATA_W-1:0] word
);
    logic [LINE_W-1:0] line_q;
    logic [BW-1:0]     beat_q;
    logic [DATA_W-1:0] words [BEATS];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            beat_q <= '0;
        end else begin
            if (capture) line_q <= line_in;
            if (clear) begin
                beat_q <= '0;
            end else if (advance) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        assign words[g] = line_q[g*DATA_W +: DATA_W];
    end

    assign word      = words[beat_q];
    assign beat_idx  = beat_q;
    assign last_beat = (beat_q == BW'(BEATS - 1));
endmodule

// File: rtl/lwr_seq.sv
module lwr_seq
    import lwr_pkg::*;
#(
    parameter int ADDR_W = LW_ADDR_W,
    parameter int ATTR_W = LW_ATTR_W,
    parameter int DATA_W = LW_DATA_W,
    parameter int BEATS  = LW_BEATS,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int LINE_W = DATA_W * BEATS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [ATTR_W-1:0]   req_attr,
    input  logic [LINE_W-1:0]   req_data,
    input  logic                cfg_ign_en,
    input  logic [LW_IGN_W-1:0] cfg_ign_cnt,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [ATTR_W-1:0]   bus_attr,
    output logic                bus_ts,
    output logic                bus_tip,
    output logic                bus_rw,
    output logic [1:0]          bus_siz,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_oe,
    output logic                bus_sas,
    input  logic                bus_ta,
    input  logic                bus_tbi,
    output logic                done,
    output logic                burst_refused
);
    lw_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [ATTR_W-1:0] attr_q;
    logic              refused_q;
    ign_cfg_t          cfg;

    logic              accept, in_beat, sample, first_sample, ack;
    logic              finish, load, advance;
    logic [BW-1:0]     beat_idx;
    logic              last_beat;
    logic [DATA_W-1:0] word;

    assign cfg.enable = cfg_ign_en;
    assign cfg.count  = cfg_ign_cnt;

    assign accept  = (state_q == S_IDLE) && req_valid;
    assign in_beat = (state_q == S_BEAT);
    assign ack     = sample && bus_ta;
    // Burst inhibit only matters with the first acknowledge of the line.
    assign finish  = last_beat || ((beat_idx == '0) && bus_tbi);
    assign load    = (state_q == S_ADDR) || (in_beat && ack && !finish);
    assign advance = in_beat && ack && !finish;

    lwr_ign_timer #(.CNT_W(LW_IGN_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .active (in_beat),
        .delay  (ign_delay(cfg)),
        .sample (sample),
        .first  (first_sample)
    );

    lwr_beat_path #(.DATA_W(DATA_W), .BEATS(BEATS)) u_beats (
        .clk       (clk),
        .rst       (rst),
        .capture   (accept),
        .line_in   (req_data),
        .clear     (state_q == S_ADDR),
        .advance   (advance),
        .beat_idx  (beat_idx),
        .last_beat (last_beat),
        .word      (word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_ADDR;
            S_ADDR: state_d = S_BEAT;
            S_BEAT: if (ack && finish) state_d = S_END;
            S_END:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            addr_q    <= '0;
            attr_q    <= '0;
            refused_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q    <= req_addr;
                attr_q    <= req_attr;
                refused_q <= 1'b0;
            end else if (in_beat && ack && (beat_idx == '0) && bus_tbi) begin
                refused_q <= 1'b1;
            end
        end
    end

    assign req_ready     = (state_q == S_IDLE);
    assign bus_addr      = addr_q;
    assign bus_attr      = attr_q;
    assign bus_ts        = (state_q == S_ADDR);
    assign bus_tip       = (state_q == S_ADDR) || in_beat;
    assign bus_rw        = !bus_tip;
    assign bus_siz       = bus_tip ? SIZ_LINE : SIZ_NONE;
    assign bus_oe        = in_beat;
    assign bus_dout      = in_beat ? word : '0;
    assign bus_sas       = first_sample;
    assign done          = (state_q == S_END);
    assign burst_refused = (state_q == S_END) && refused_q;
endmodule

// File: rtl/lwr_seq_chk.sv
module lwr_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ts,
    input logic              bus_tip,
    input logic              bus_rw,
    input logic [1:0]        bus_siz,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_oe,
    input logic              bus_sas,
    input logic              bus_ta,
    input logic              done,
    input logic              burst_refused
);
    p_ts_single_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ts |=> !bus_ts);
    p_ts_with_tip_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ts |-> bus_tip);
    p_write_line_r2: assert property (@(posedge clk) disable iff (rst)
        bus_tip |-> (!bus_rw && bus_siz == 2'b11));
    p_data_after_start_r3: assert property (@(posedge clk) disable iff (rst)
        bus_ts |=> (bus_oe && !bus_ts));
    p_sas_while_driving_r5: assert property (@(posedge clk) disable iff (rst)
        bus_sas |-> bus_oe);
    p_wait_holds_data_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !bus_ta) |=> (!bus_oe || $stable(bus_dout)));
    p_refused_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        burst_refused |-> done);
    p_release_at_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_oe && !bus_tip));
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
    p_addr_held_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_tip && !bus_ts) |-> $stable(bus_addr));
endmodule

bind lwr_seq lwr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .bus_addr      (bus_addr),
    .bus_ts        (bus_ts),
    .bus_tip       (bus_tip),
    .bus_rw        (bus_rw),
    .bus_siz       (bus_siz),
    .bus_dout      (bus_dout),
    .bus_oe        (bus_oe),
    .bus_sas       (bus_sas),
    .bus_ta        (bus_ta),
    .done          (done),
    .burst_refused (burst_refused)
);

// File: tb/lwr_seq_bench.sv
`timescale 1ns/1ps
module lwr_seq_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [4:0]   req_attr = '0;
    logic [127:0] req_data = '0;
    logic         cfg_ign_en = 1'b0;
    logic [2:0]   cfg_ign_cnt = '0;
    logic [31:0]  bus_addr;
    logic [4:0]   bus_attr;
    logic         bus_ts, bus_tip, bus_rw, bus_oe, bus_sas;
    logic [1:0]   bus_siz;
    logic [31:0]  bus_dout;
    logic         bus_ta = 1'b0;
    logic         bus_tbi = 1'b0;
    logic         done, burst_refused;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lwr_seq u_lwr_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_attr(req_attr), .req_data(req_data),
        .cfg_ign_en(cfg_ign_en), .cfg_ign_cnt(cfg_ign_cnt),
        .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_ts(bus_ts),
        .bus_tip(bus_tip), .bus_rw(bus_rw), .bus_siz(bus_siz),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_sas(bus_sas),
        .bus_ta(bus_ta), .bus_tbi(bus_tbi), .done(done),
        .burst_refused(burst_refused)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [127:0] line, input int i);
        return line[i*32 +: 32];
    endfunction

    function automatic int delay_of(input logic en, input logic [2:0] cnt);
        return en ? int'(cnt) : 0;
    endfunction

    // ack_mode 0: acknowledge at the first live clock; 1: random waits.
    task automatic run_line(input logic en, input logic [2:0] cnt,
                            input logic refuse, input int ack_mode);
        logic [31:0]  a = $urandom;
        logic [4:0]   at = 5'($urandom);
        logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
        int dly = delay_of(en, cnt);
        int beats_done = 0;
        bit refused = 0;
        cfg_ign_en = en; cfg_ign_cnt = cnt;
        req_addr = a; req_attr = at; req_data = d; req_valid = 1'b1;
        chk("R1 ready before request", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        // address clock; acknowledge here must be ignored
        bus_ta = 1'b1; bus_tbi = 1'b1;
        chk("R2 ts in address clock", {63'd0, bus_ts}, 64'd1);
        chk("R2 tip in address clock", {63'd0, bus_tip}, 64'd1);
        chk("R2 rw low", {63'd0, bus_rw}, 64'd0);
        chk("R2 size line", {62'd0, bus_siz}, 64'd3);
        chk("R2 address", {32'd0, bus_addr}, {32'd0, a});
        chk("R2 attributes", {59'd0, bus_attr}, {59'd0, at});
        chk("R3 bus released in address clock", {63'd0, bus_oe}, 64'd0);
        chk("R11 ready low while busy", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            int k = 0;
            bit got = 0;
            while (!got) begin
                logic ta_v, tbi_v;
                chk(b == 0 && k == 0 ? "R3 ts low, data driven" : "R7 bus driven in beat",
                    {62'd0, bus_ts, bus_oe}, 64'd1);
                chk(b == 0 ? "R3 word 0 on bus" : "R7 word order",
                    {32'd0, bus_dout}, {32'd0, word_of(d, b)});
                chk(dly == 0 ? "R4 sampling status" : "R5 sampling status after ignore",
                    {63'd0, bus_sas}, {63'd0, k == dly});
                chk("R2 rw and size held", {61'd0, bus_rw, bus_siz}, 64'd3);
                chk("R11 address held", {32'd0, bus_addr}, {32'd0, a});
                chk("R10 no done mid line", {62'd0, done, bus_tip}, 64'd1);
                req_valid = $urandom_range(0, 1);
                req_addr = $urandom;
                if (k < dly) begin
                    ta_v = 1'b1;            // R5: must be ignored
                    tbi_v = 1'b1;
                end else begin
                    ta_v = (ack_mode == 0) ? 1'b1 :
                           (k > dly + 4) ? 1'b1 : 1'($urandom_range(0, 1));
                    tbi_v = (b == 0 && ta_v) ? refuse : 1'($urandom_range(0, 1));
                end
                bus_ta = ta_v; bus_tbi = tbi_v;
                @(negedge clk);
                if (k >= dly && ta_v) got = 1;
                k++;
            end
            beats_done++;
            if (b == 0 && refuse) begin refused = 1; break; end
        end
        req_valid = 1'b0; bus_ta = 1'b0; bus_tbi = 1'b0;
        chk(refused ? "R9 one beat then end" : "R8 four beats after burst",
            beats_done, refused ? 1 : 4);
        chk("R10 done after final ack", {63'd0, done}, 64'd1);
        chk("R10 tip and bus released", {62'd0, bus_tip, bus_oe}, 64'd0);
        chk("R9 refused flag", {63'd0, burst_refused}, {63'd0, refused});
        chk("R11 no new start", {63'd0, bus_ts}, 64'd0);
        @(negedge clk);
        chk("R10 done one clock", {63'd0, done}, 64'd0);
        chk("R10 ready after done", {63'd0, req_ready}, 64'd1);
        chk("R11 no start after busy request", {62'd0, bus_ts, bus_tip}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1 reset tip/ts", {62'd0, bus_tip, bus_ts}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle outputs", {58'd0, bus_ts, bus_tip, bus_oe, bus_sas, done, burst_refused}, 64'd0);
        chk("R1 idle rw/size", {61'd0, bus_rw, bus_siz}, 64'd4);
        chk("R1 ready", {63'd0, req_ready}, 64'd1);
        run_line(1'b0, 3'd5, 1'b0, 0);   // R4 disabled, count ignored
        run_line(1'b1, 3'd0, 1'b0, 1);   // R4 zero count
        run_line(1'b1, 3'd7, 1'b1, 0);   // R5/R9 max delay, refused
        run_line(1'b1, 3'd1, 1'b0, 0);   // R5 delay expiry same edge as ack
        run_line(1'b0, 3'd0, 1'b1, 1);   // R9 with waits
        for (int i = 0; i < 60; i++) begin
            run_line(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                     ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired R10 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule